// File: doc/BRIEF.md
# Bit-Serial Arithmetic/Logic Unit with Parity Flag

This block performs 8-bit arithmetic and logic one bit per clock, least significant bit first. A one-cycle `start` pulse selects one of eight operations and opens an operation. Each later cycle with `bit_en` high takes one accumulator bit and one source bit and returns one result bit on the next cycle. After the eighth bit the unit commits four status flags: carry, zero, sign and parity. There is no overflow flag. Parity comes from a running XOR of the result bits, which costs one flip-flop in serial form.

The carry flag persists between operations. Values wider than a byte are processed low byte first, using add-with-carry or subtract-with-borrow for every byte after the first. Compare runs a subtraction that sets the flags, and it keeps the write enable low so the accumulator is not written. Logic operations clear carry.

Top module: `serial_alu`

## Requirements
- R1: A `start` pulse latches `op` and opens an operation. Each later cycle with `bit_en` high consumes one bit pair, LSB first. The result bit appears on `res_bit` with `res_valid` high one clock after that bit is taken.
- R2: Op code 0 is add. The eight result bits equal (A + B) mod 256. The carry flag is the carry out of bit 7.
- R3: Op code 1 is add with carry. The current carry flag is added in, so chaining bytes low byte first forms a correct multi-byte sum.
- R4: Op code 2 is subtract. The result is (A − B) mod 256. The carry flag is 1 exactly when A < B (borrow).
- R5: Op code 3 is subtract with borrow. The result is A − B − carry flag, and the carry flag receives the new borrow. Chaining bytes forms a correct multi-byte difference.
- R6: Op codes 4, 5 and 6 are bitwise AND, XOR and OR. Each of them clears the carry flag.
- R7: Op code 7 is compare. It sets all four flags exactly as subtract would, and `wr_en` stays low for all of its result bits. For every other op code, `wr_en` accompanies each `res_valid`.
- R8: The zero flag is 1 exactly when all eight result bits are 0.
- R9: The sign flag equals result bit 7.
- R10: The parity flag is 1 exactly when the result holds an even number of 1 bits.
- R11: The flags and a one-cycle `done` pulse change only at the clock edge that takes the eighth bit. Before that edge, the flags hold their previous values.
- R12: A `bit_en` that arrives while no operation is open is ignored. `res_valid` and `done` stay low and the flags are unchanged.
- R13: After reset, all flags, `done`, `res_valid` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Opens an operation and latches `op` |
| op | input | 3 | Operation code (0 add … 7 compare) |
| bit_en | input | 1 | A bit pair is present this cycle |
| a_bit | input | 1 | Accumulator operand bit |
| b_bit | input | 1 | Source operand bit |
| res_bit | output | 1 | Result bit |
| res_valid | output | 1 | `res_bit` holds a result bit |
| wr_en | output | 1 | Result bit may be written back (low for compare) |
| done | output | 1 | One-cycle pulse: flags just updated |
| flag_carry | output | 1 | Carry / borrow flag |
| flag_zero | output | 1 | Zero flag |
| flag_sign | output | 1 | Sign flag |
| flag_parity | output | 1 | Even-parity flag |

## Verification
Each result bit is registered once, so it is due one clock after the edge that takes its operand bits. The flags and `done` are due at the edge that takes the eighth bit. The bench drives inputs on the falling edge and samples on the next falling edge. That sample reads the output of the bit driven one half-period before the edge, and after the eighth bit it reads `done` and the four flags. At each intermediate sample the bench also confirms that the flags still show the previous operation's values and that `done` is low.

// File: rtl/serial_alu_pkg.sv
// Shared types for the bit-serial ALU.
package serial_alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    // True for the operations that add the inverted source.
    function automatic logic op_is_sub(alu_op_e o);
        return (o == OP_SUB) || (o == OP_SBB) || (o == OP_CMP);
    endfunction

    // True for the bitwise operations.
    function automatic logic op_is_logic(alu_op_e o);
        return (o == OP_AND) || (o == OP_XOR) || (o == OP_OR);
    endfunction
endpackage

// File: rtl/serial_alu_ctrl.sv
// Sequencer: opens an operation on start, counts the bits taken and
// flags the last one. Assumes start and bit_en are synchronous to clk;
// start has priority over bit_en in the same cycle.
module serial_alu_ctrl
    import serial_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic [2:0] op,
    input  logic    bit_en,
    output alu_op_e op_q,
    output logic    step,
    output logic    last
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIDTH - 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;

    // A bit is taken only inside an open operation and never together with start.
    assign step = busy && bit_en && !start;
    assign last = step && (cnt == LAST_IDX);

    // Tracks the open operation, its latched code and the bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            op_q <= OP_ADD;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            op_q <= alu_op_e'(op);
        end else if (step) begin
            cnt <= cnt + 1'b1;
            if (last) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serial_alu_datapath.sv
// One-bit slice: full adder with optional source inversion, the bitwise
// operations, and the carry-chain register seeded at start. Registers
// the result bit and its write enable. Assumes carry_flag is stable at start.
module serial_alu_datapath
    import serial_alu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic [2:0] op,
    input  alu_op_e op_q,
    input  logic    step,
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    carry_flag,
    output logic    sum_bit,
    output logic    cout,
    output logic    res_bit,
    output logic    res_valid,
    output logic    wr_en
);
    logic cy;
    logic b_eff;

    // Combinational bit result and carry out for the selected operation.
    always_comb begin
        b_eff = op_is_sub(op_q) ? ~b_bit : b_bit;
        cout  = (a_bit & b_eff) | (cy & (a_bit ^ b_eff));
        unique case (op_q)
            OP_AND:  sum_bit = a_bit & b_bit;
            OP_XOR:  sum_bit = a_bit ^ b_bit;
            OP_OR:   sum_bit = a_bit | b_bit;
            default: sum_bit = a_bit ^ b_eff ^ cy;
        endcase
    end

    // Carry chain: seeded per operation at start, then advanced each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cy <= 1'b0;
        end else if (start) begin
            unique case (alu_op_e'(op))
                OP_ADC:         cy <= carry_flag;
                OP_SUB, OP_CMP: cy <= 1'b1;
                OP_SBB:         cy <= ~carry_flag;
                default:        cy <= 1'b0;
            endcase
        end else if (step) begin
            cy <= cout;
        end
    end

    // Result bit register with valid and write-back enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_bit   <= 1'b0;
            res_valid <= 1'b0;
            wr_en     <= 1'b0;
        end else begin
            res_bit   <= step ? sum_bit : res_bit;
            res_valid <= step;
            wr_en     <= step && (op_q != OP_CMP);
        end
    end
endmodule

// File: rtl/serial_alu_flags.sv
// Flag unit: sticky OR for zero and running XOR for parity, cleared at
// start, plus the four committed flags written only on the last bit.
// Assumes last implies step.
module serial_alu_flags
    import serial_alu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    step,
    input  logic    last,
    input  alu_op_e op_q,
    input  logic    sum_bit,
    input  logic    cout,
    output logic    done,
    output logic    flag_carry,
    output logic    flag_zero,
    output logic    flag_sign,
    output logic    flag_parity
);
    logic any_one;
    logic odd_acc;

    // Running accumulators over the bits of the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            any_one <= 1'b0;
            odd_acc <= 1'b0;
        end else if (step) begin
            any_one <= any_one | sum_bit;
            odd_acc <= odd_acc ^ sum_bit;
        end
    end

    // Commits the flags and pulses done at the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            flag_carry  <= 1'b0;
            flag_zero   <= 1'b0;
            flag_sign   <= 1'b0;
            flag_parity <= 1'b0;
        end else begin
            done <= last;
            if (last) begin
                flag_zero   <= ~(any_one | sum_bit);
                flag_parity <= ~(odd_acc ^ sum_bit);
                flag_sign   <= sum_bit;
                if (op_is_logic(op_q)) begin
                    flag_carry <= 1'b0;
                end else if (op_is_sub(op_q)) begin
                    flag_carry <= ~cout;
                end else begin
                    flag_carry <= cout;
                end
            end
        end
    end
endmodule

// File: rtl/serial_alu.sv
// Bit-serial ALU top: LSB-first operands, eight operations, four flags.
// Assumes the caller presents exactly WIDTH bits per operation after start.
module serial_alu
    import serial_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [2:0] op,
    input  logic       bit_en,
    input  logic       a_bit,
    input  logic       b_bit,
    output logic       res_bit,
    output logic       res_valid,
    output logic       wr_en,
    output logic       done,
    output logic       flag_carry,
    output logic       flag_zero,
    output logic       flag_sign,
    output logic       flag_parity
);
    alu_op_e op_q;
    logic    step;
    logic    last;
    logic    sum_bit;
    logic    cout;

    serial_alu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .op     (op),
        .bit_en (bit_en),
        .op_q   (op_q),
        .step   (step),
        .last   (last)
    );

    serial_alu_datapath u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op         (op),
        .op_q       (op_q),
        .step       (step),
        .a_bit      (a_bit),
        .b_bit      (b_bit),
        .carry_flag (flag_carry),
        .sum_bit    (sum_bit),
        .cout       (cout),
        .res_bit    (res_bit),
        .res_valid  (res_valid),
        .wr_en      (wr_en)
    );

    serial_alu_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .step        (step),
        .last        (last),
        .op_q        (op_q),
        .sum_bit     (sum_bit),
        .cout        (cout),
        .done        (done),
        .flag_carry  (flag_carry),
        .flag_zero   (flag_zero),
        .flag_sign   (flag_sign),
        .flag_parity (flag_parity)
    );
endmodule

// File: rtl/serial_alu_chk.sv
// Property checker for serial_alu, attached by bind below.
module serial_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       res_valid,
    input logic       wr_en,
    input logic       done,
    input logic       flag_carry,
    input logic       flag_zero,
    input logic       flag_sign,
    input logic       flag_parity,
    input logic [2:0] op_q
);
    AST_VALID_FOLLOWS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(bit_en)); // R1
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (op_q != 3'd7)); // R7
    AST_LOGIC_CARRY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q[2] && (op_q != 3'd7)) |-> !flag_carry); // R6
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({flag_carry, flag_zero, flag_sign, flag_parity})); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ZERO_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_zero) |-> (!flag_sign && flag_parity)); // R8
endmodule

bind serial_alu serial_alu_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .res_valid   (res_valid),
    .wr_en       (wr_en),
    .done        (done),
    .flag_carry  (flag_carry),
    .flag_zero   (flag_zero),
    .flag_sign   (flag_sign),
    .flag_parity (flag_parity),
    .op_q        (op_q)
);

// File: tb/sim_serial_alu.sv
`timescale 1ns/1ps
module sim_serial_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] op = 3'd0;
    logic       bit_en = 1'b0;
    logic       a_bit = 1'b0;
    logic       b_bit = 1'b0;
    logic       res_bit, res_valid, wr_en, done;
    logic       flag_carry, flag_zero, flag_sign, flag_parity;

    int   n_chk = 0;
    int   n_bad = 0;
    logic exp_cf = 1'b0;

    always #2 clk = ~clk;

    serial_alu u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_en(bit_en),
        .a_bit(a_bit), .b_bit(b_bit), .res_bit(res_bit), .res_valid(res_valid),
        .wr_en(wr_en), .done(done), .flag_carry(flag_carry), .flag_zero(flag_zero),
        .flag_sign(flag_sign), .flag_parity(flag_parity)
    );

    // Records one comparison.
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference: returns {carry, result} for one byte.
    function automatic logic [8:0] model(input logic [2:0] o, input logic [7:0] a,
                                         input logic [7:0] b, input logic cf);
        logic [8:0] s;
        case (o)
            3'd0: begin s = {1'b0, a} + {1'b0, b}; return s; end
            3'd1: begin s = {1'b0, a} + {1'b0, b} + {8'd0, cf}; return s; end
            3'd2, 3'd7: begin s = {1'b0, a} + {1'b0, ~b} + 9'd1; return {~s[8], s[7:0]}; end
            3'd3: begin s = {1'b0, a} + {1'b0, ~b} + {8'd0, ~cf}; return {~s[8], s[7:0]}; end
            3'd4: return {1'b0, a & b};
            3'd5: return {1'b0, a ^ b};
            default: return {1'b0, a | b};
        endcase
    endfunction

    // Runs one byte operation and checks result, write enable, hold and flags.
    task automatic run_op(input string req, input logic [2:0] o,
                          input logic [7:0] a, input logic [7:0] b,
                          output logic [7:0] got);
        logic [8:0] m;
        logic [3:0] prev;
        logic [3:0] expf;
        logic       hold_ok;
        logic       wr_ok;
        m     = model(o, a, b, exp_cf);
        expf  = {m[8], (m[7:0] == 8'd0), m[7], ~^m[7:0]};
        prev  = {flag_carry, flag_zero, flag_sign, flag_parity};
        hold_ok = 1'b1;
        wr_ok   = 1'b1;
        got     = 8'd0;
        @(negedge clk);
        start = 1'b1; op = o;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i <= 8; i++) begin
            if (i > 0) begin
                @(negedge clk);
                got[i-1] = res_bit;
                if (!res_valid) hold_ok = 1'b0;
                if (wr_en !== (o != 3'd7)) wr_ok = 1'b0;
                if (i < 8 && (done || {flag_carry, flag_zero, flag_sign, flag_parity} != prev))
                    hold_ok = 1'b0;
            end
            if (i < 8) begin
                bit_en = 1'b1; a_bit = a[i]; b_bit = b[i];
            end else begin
                bit_en = 1'b0;
            end
        end
        if (o != 3'd7) check(req, "result", got, m[7:0]);
        check("R7", "wr_en pattern", wr_ok, 1'b1);
        check("R11", "flags held and valid during bits", hold_ok, 1'b1);
        check("R11", "done at last bit", done, 1'b1);
        check(req, "carry", flag_carry, m[8]);
        check("R8", "zero", flag_zero, expf[2]);
        check("R9", "sign", flag_sign, expf[1]);
        check("R10", "parity", flag_parity, expf[0]);
        exp_cf = m[8];
        @(negedge clk);
        check("R11", "done one cycle", done, 1'b0);
    endtask

    task automatic t_reset();
        check("R13", "flags after reset", {flag_carry, flag_zero, flag_sign, flag_parity}, 4'd0);
        check("R13", "done/valid/wr after reset", {done, res_valid, wr_en}, 3'd0);
    endtask

    task automatic t_add();
        logic [7:0] r;
        run_op("R2", 3'd0, 8'h35, 8'h1A, r);
        run_op("R2", 3'd0, 8'hF0, 8'h20, r);
        run_op("R2", 3'd0, 8'hFF, 8'h01, r);
    endtask

    // 16-bit add chained low byte first: 0x12FF + 0x0E01 = 0x2100.
    task automatic t_adc_chain();
        logic [7:0] lo, hi;
        run_op("R2", 3'd0, 8'hFF, 8'h01, lo);
        run_op("R3", 3'd1, 8'h12, 8'h0E, hi);
        check("R3", "16-bit sum", {hi, lo}, 16'h2100);
    endtask

    task automatic t_sub();
        logic [7:0] r;
        run_op("R4", 3'd2, 8'h50, 8'h20, r);
        run_op("R4", 3'd2, 8'h03, 8'h05, r);
        run_op("R4", 3'd2, 8'h77, 8'h77, r);
    endtask

    // 16-bit difference: 0x0100 - 0x0001 = 0x00FF.
    task automatic t_sbb_chain();
        logic [7:0] lo, hi;
        run_op("R4", 3'd2, 8'h00, 8'h01, lo);
        run_op("R5", 3'd3, 8'h01, 8'h00, hi);
        check("R5", "16-bit difference", {hi, lo}, 16'h00FF);
    endtask

    task automatic t_logic();
        logic [7:0] r;
        run_op("R4", 3'd2, 8'h00, 8'h01, r);      // leave carry set first
        run_op("R6", 3'd4, 8'hCC, 8'hAA, r);
        run_op("R6", 3'd5, 8'hCC, 8'hAA, r);
        run_op("R6", 3'd6, 8'hC0, 8'h0A, r);
    endtask

    task automatic t_cmp();
        logic [7:0] r;
        run_op("R7", 3'd7, 8'h10, 8'h20, r);
        run_op("R7", 3'd7, 8'h42, 8'h42, r);
    endtask

    // Even and odd parity, zero with nonzero operands.
    task automatic t_corners();
        logic [7:0] r;
        run_op("R10", 3'd5, 8'h5A, 8'h5A, r);
        run_op("R10", 3'd6, 8'h01, 8'h00, r);
        run_op("R9", 3'd6, 8'h80, 8'h7F, r);
    endtask

    // Bits offered with no open operation are ignored.
    task automatic t_ignored();
        logic [3:0] prev;
        logic       quiet;
        prev  = {flag_carry, flag_zero, flag_sign, flag_parity};
        quiet = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (res_valid || done) quiet = 1'b0;
            bit_en = 1'b1; a_bit = i[0]; b_bit = 1'b1;
        end
        @(negedge clk);
        if (res_valid || done) quiet = 1'b0;
        bit_en = 1'b0;
        @(negedge clk);
        if (res_valid || done) quiet = 1'b0;
        check("R12", "no valid/done when idle", quiet, 1'b1);
        check("R12", "flags untouched when idle",
              {flag_carry, flag_zero, flag_sign, flag_parity}, prev);
    endtask

    task automatic t_random();
        logic [7:0] r;
        for (int k = 0; k < 40; k++) begin
            logic [2:0] o;
            o = 3'($urandom_range(0, 7));
            run_op("R2", o, 8'($urandom), 8'($urandom), r);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_adc_chain();
        t_sub();
        t_sbb_chain();
        t_logic();
        t_cmp();
        t_corners();
        t_ignored();
        t_random();
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule